// File: doc/BRIEF.md
# Packed Word Shuffle Execution Unit

This execution unit rearranges the four 16-bit words of a 64-bit operand. An 8-bit order byte holds four 2-bit selectors, one for each destination word position. Each selector names the source word that is copied into that position. Nothing stops two or more selectors from naming the same source word, so a single word can be broadcast or duplicated.

A request is a single-cycle strobe. Along with the operand and the order byte it carries the processor state that decides whether the operation may complete: an emulation flag, a task-switched flag, a pending floating-point exception flag, an alignment-check enable, the current privilege level, a flag that marks a memory operand, and the low three address bits. One cycle after the request the unit returns a registered response strobe and a 3-bit fault code. The shuffled result register is written only when that fault code is zero. Address translation, segment checks and memory access are handled elsewhere.

Top module: `word_shuffle_unit`

## Requirements
- R1: Word k of the operand is bits 16k+15:16k. Destination word k of `rsp_result` equals the source word whose index is `req_order[2k+1:2k]`. For example, selector value 2 picks source bits 47:32.
- R2: A source word may fill any number of destination positions. Order byte 0x00 copies word 0 into all four positions, and 0xFF copies word 3 into all four.
- R3: `rsp_valid` is high in exactly the cycles that follow a cycle in which `req_valid` was high.
- R4: When the emulation flag is set, `rsp_fault` is 1 (invalid opcode), whatever the other flags are.
- R5: When the task-switched flag is set and the emulation flag is clear, `rsp_fault` is 2 (device not available).
- R6: When a floating-point exception is pending and neither of the two flags above is set, `rsp_fault` is 3 (floating-point error).
- R7: When alignment checking is enabled, the operand comes from memory, the privilege level is 3 and `req_addr_lo` is nonzero, and none of the conditions above holds, `rsp_fault` is 4 (alignment check).
- R8: If any one of those alignment conditions is missing (checking disabled, register operand, privilege below 3, or address aligned), the unit reports fault 0 and writes the result.
- R9: A response with a nonzero fault code leaves `rsp_result` equal to its previous value.
- R10: After reset, `rsp_valid` is 0, `rsp_result` is 0 and `rsp_fault` is 0.
- R11: In a cycle that follows a cycle with no request, `rsp_result` and `rsp_fault` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_src | input | 64 | Source operand |
| req_order | input | 8 | Four 2-bit word selectors |
| req_emu | input | 1 | Emulation flag |
| req_ts | input | 1 | Task-switched flag |
| req_fp_pend | input | 1 | Pending floating-point exception |
| req_ac_en | input | 1 | Alignment checking enabled |
| req_cpl | input | 2 | Current privilege level |
| req_mem | input | 1 | Operand comes from memory |
| req_addr_lo | input | 3 | Low address bits of the memory operand |
| rsp_valid | output | 1 | Response strobe |
| rsp_result | output | 64 | Shuffled result register |
| rsp_fault | output | 3 | Fault code: 0 none, 1 invalid opcode, 2 device not available, 3 floating-point error, 4 alignment check |

## Verification
The assertions check the timing and the holding behaviour on every cycle: the response strobe follows the request by one cycle, the result does not move when a fault is reported, both outputs hold when no request came in, and the two highest-priority fault codes appear whenever their flags were set. The word routing for all 256 order bytes, the lower fault priorities, and the cases where the alignment check must stay quiet can only be shown by the bench's scenarios, which compare each response against a behavioural reference model.

// File: rtl/wsu_pkg.sv
package wsu_pkg;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_INVOP = 3'd1,
        FLT_DEVNA = 3'd2,
        FLT_FPERR = 3'd3,
        FLT_ALIGN = 3'd4
    } fault_e;

endpackage

// File: rtl/wsu_lane_sel.sv
// One destination lane: picks a source word by index.
module wsu_lane_sel #(
    parameter int WORD_W = 16,
    parameter int LANES  = 4,
    localparam int SEL_W  = $clog2(LANES),
    localparam int DATA_W = WORD_W * LANES
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] word
);

    always_comb begin
        word = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel == SEL_W'(k)) begin
                word = src[k*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/wsu_shuffle.sv
// Full shuffle network: one selector per destination lane.
module wsu_shuffle #(
    parameter int WORD_W = 16,
    parameter int LANES  = 4,
    localparam int SEL_W   = $clog2(LANES),
    localparam int DATA_W  = WORD_W * LANES,
    localparam int ORDER_W = SEL_W * LANES
) (
    input  logic [DATA_W-1:0]  src,
    input  logic [ORDER_W-1:0] order,
    output logic [DATA_W-1:0]  dst
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wsu_lane_sel #(
            .WORD_W(WORD_W),
            .LANES (LANES)
        ) u_sel (
            .src (src),
            .sel (order[g*SEL_W +: SEL_W]),
            .word(dst[g*WORD_W +: WORD_W])
        );
    end

endmodule

// File: rtl/wsu_fault_arb.sv
// Prioritised fault decision for one request.
module wsu_fault_arb
    import wsu_pkg::*;
#(
    parameter int CPL_W      = 2,
    parameter int ALIGN_BYTES = 8,
    localparam int ADDR_LO_W = $clog2(ALIGN_BYTES)
) (
    input  logic                 emu,
    input  logic                 ts,
    input  logic                 fp_pend,
    input  logic                 ac_en,
    input  logic [CPL_W-1:0]     cpl,
    input  logic                 mem_op,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    output fault_e               fault
);

    logic user_level;
    logic misaligned;
    logic align_hit;

    always_comb begin
        user_level = &cpl;
        misaligned = |addr_lo;
        align_hit  = ac_en && mem_op && user_level && misaligned;

        if (emu) begin
            fault = FLT_INVOP;
        end else if (ts) begin
            fault = FLT_DEVNA;
        end else if (fp_pend) begin
            fault = FLT_FPERR;
        end else if (align_hit) begin
            fault = FLT_ALIGN;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/word_shuffle_unit.sv
module word_shuffle_unit
    import wsu_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int LANES       = 4,
    parameter int CPL_W       = 2,
    parameter int ALIGN_BYTES = 8,
    localparam int SEL_W      = $clog2(LANES),
    localparam int DATA_W     = WORD_W * LANES,
    localparam int ORDER_W    = SEL_W * LANES,
    localparam int ADDR_LO_W  = $clog2(ALIGN_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [DATA_W-1:0]    req_src,
    input  logic [ORDER_W-1:0]   req_order,
    input  logic                 req_emu,
    input  logic                 req_ts,
    input  logic                 req_fp_pend,
    input  logic                 req_ac_en,
    input  logic [CPL_W-1:0]     req_cpl,
    input  logic                 req_mem,
    input  logic [ADDR_LO_W-1:0] req_addr_lo,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_result,
    output logic [2:0]           rsp_fault
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        fault_e            flt;
    } rsp_state_t;

    rsp_state_t        st_d, st_q;
    logic [DATA_W-1:0] shuf_w;
    fault_e            fault_w;

    wsu_shuffle #(
        .WORD_W(WORD_W),
        .LANES (LANES)
    ) u_shuffle (
        .src  (req_src),
        .order(req_order),
        .dst  (shuf_w)
    );

    wsu_fault_arb #(
        .CPL_W      (CPL_W),
        .ALIGN_BYTES(ALIGN_BYTES)
    ) u_fault (
        .emu    (req_emu),
        .ts     (req_ts),
        .fp_pend(req_fp_pend),
        .ac_en  (req_ac_en),
        .cpl    (req_cpl),
        .mem_op (req_mem),
        .addr_lo(req_addr_lo),
        .fault  (fault_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.flt = fault_w;
            if (fault_w == FLT_NONE) begin
                st_d.res = shuf_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
            st_q.res <= '0;
            st_q.flt <= FLT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.vld;
    assign rsp_result = st_q.res;
    assign rsp_fault  = st_q.flt;

endmodule

// File: rtl/wsu_chk.sv
module wsu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_emu,
    input logic              req_ts,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_result,
    input logic [2:0]        rsp_fault
);

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    invop_top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_emu) |=> (rsp_fault == 3'd1));

    // R5
    devna_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_emu && req_ts) |=> (rsp_fault == 3'd2));

    // R9
    fault_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> $stable(rsp_result));

    // R11
    idle_holds_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_result) && $stable(rsp_fault)));

endmodule

bind word_shuffle_unit wsu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_emu   (req_emu),
    .req_ts    (req_ts),
    .rsp_valid (rsp_valid),
    .rsp_result(rsp_result),
    .rsp_fault (rsp_fault)
);

// File: tb/sim_word_shuffle_unit.sv
`timescale 1ns/1ps
module sim_word_shuffle_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_src = '0;
    logic [7:0]  req_order = '0;
    logic        req_emu = 1'b0, req_ts = 1'b0, req_fp_pend = 1'b0;
    logic        req_ac_en = 1'b0, req_mem = 1'b0;
    logic [1:0]  req_cpl = '0;
    logic [2:0]  req_addr_lo = '0;
    logic        rsp_valid;
    logic [63:0] rsp_result;
    logic [2:0]  rsp_fault;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] m_res = '0;
    logic [2:0]  m_flt = '0;

    always #2 clk = ~clk;

    word_shuffle_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_order(req_order), .req_emu(req_emu), .req_ts(req_ts),
        .req_fp_pend(req_fp_pend), .req_ac_en(req_ac_en), .req_cpl(req_cpl),
        .req_mem(req_mem), .req_addr_lo(req_addr_lo),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_fault(rsp_fault)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_shuffle(input logic [63:0] s, input logic [7:0] o);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = (o >> (2 * k)) & 3;
            r[16*k +: 16] = 16'((s >> (idx * 16)) & 64'hFFFF);
        end
        return r;
    endfunction

    function automatic logic [2:0] ref_fault(input logic e, t, f, ac, input logic [1:0] c,
                                             input logic m, input logic [2:0] a);
        if (e) return 3'd1;
        if (t) return 3'd2;
        if (f) return 3'd3;
        if (ac && m && c == 2'd3 && a != 3'd0) return 3'd4;
        return 3'd0;
    endfunction

    // Drive one request (called just after a falling edge), check the response.
    task automatic send(input logic [63:0] s, input logic [7:0] o, input logic e, t, f, ac,
                        input logic [1:0] c, input logic m, input logic [2:0] a,
                        input string tag);
        logic [63:0] prev;
        prev = m_res;
        req_valid = 1'b1; req_src = s; req_order = o; req_emu = e; req_ts = t;
        req_fp_pend = f; req_ac_en = ac; req_cpl = c; req_mem = m; req_addr_lo = a;
        m_flt = ref_fault(e, t, f, ac, c, m, a);
        if (m_flt == 3'd0) m_res = ref_shuffle(s, o);
        @(negedge clk);
        check({tag, " valid R3"}, 64'(rsp_valid), 64'd1);
        check({tag, " fault"}, 64'(rsp_fault), 64'(m_flt));
        check({tag, " result"}, rsp_result, m_res);
        if (m_flt != 3'd0) check({tag, " held R9"}, rsp_result, prev);
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        req_src = {$urandom, $urandom};
        req_order = 8'($urandom);
        @(negedge clk);
        check({tag, " valid R3"}, 64'(rsp_valid), 64'd0);
        check({tag, " result R11"}, rsp_result, m_res);
        check({tag, " fault R11"}, 64'(rsp_fault), 64'(m_flt));
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", 64'(rsp_valid), 64'd0);
        check("R10 reset result", rsp_result, 64'd0);
        check("R10 reset fault", 64'(rsp_fault), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R2: every order byte, random operands
        for (int o = 0; o < 256; o++) begin
            string tg;
            tg = (o == 0 || o == 255) ? "R2 broadcast" : "R1 shuffle";
            send({$urandom, $urandom}, 8'(o), 0, 0, 0, 0, 2'd0, 0, 3'd0, tg);
        end
        send(64'h4444_3333_2222_1111, 8'h00, 0, 0, 0, 0, 2'd3, 0, 3'd0, "R2 word0 x4");
        send(64'h4444_3333_2222_1111, 8'hFF, 0, 0, 0, 0, 2'd3, 0, 3'd0, "R2 word3 x4");
        send(64'h4444_3333_2222_1111, 8'h1B, 0, 0, 0, 0, 2'd3, 0, 3'd0, "R1 reverse");
        idle("R11 idle");
        idle("R11 idle2");

        // R4..R7: every combination of the four fault conditions
        for (int k = 0; k < 16; k++) begin
            string tg;
            if (k[3]) tg = "R4 invop";
            else if (k[2]) tg = "R5 devna";
            else if (k[1]) tg = "R6 fperr";
            else if (k[0]) tg = "R7 align";
            else tg = "R8 clean";
            send({$urandom, $urandom}, 8'($urandom), k[3], k[2], k[1], 1'b1, 2'd3,
                 1'b1, k[0] ? 3'd3 : 3'd0, tg);
        end

        // R8: one alignment condition missing each time
        send({$urandom, $urandom}, 8'h39, 0, 0, 0, 0, 2'd3, 1, 3'd5, "R8 ac off");
        send({$urandom, $urandom}, 8'h39, 0, 0, 0, 1, 2'd3, 0, 3'd5, "R8 reg operand");
        send({$urandom, $urandom}, 8'h39, 0, 0, 0, 1, 2'd2, 1, 3'd5, "R8 cpl2");
        send({$urandom, $urandom}, 8'h39, 0, 0, 0, 1, 2'd3, 1, 3'd0, "R8 aligned");
        send({$urandom, $urandom}, 8'h39, 0, 0, 0, 1, 2'd3, 1, 3'd1, "R7 addr1");
        idle("R11 after fault");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule